// File: doc/BRIEF.md
# Overcurrent Blanking and Latch-off Timer

This block guards four high-side output channels against overcurrent. Each channel receives two comparator flags from the analog front end. One flag reports that the load current is above a low threshold, and the other reports that it is above a high threshold. A sustained low-threshold excursion is tolerated for a programmable blanking interval, so that inrush into lamps or capacitive loads does not trip the output. If the excursion outlasts that interval, the channel latches off. A high-threshold excursion skips the blanking and latches the channel off after a short fixed deglitch, which lies well inside 20 µs.

The blanking interval is chosen per channel by a 2-bit code:

| Code | Blanking interval |
|------|-------------------|
| 00   | 155 ms (default)  |
| 10   | 75 ms             |
| 11   | 150 µs            |
| 01   | reserved          |

The intervals are converted to clock cycles from a clock-frequency parameter. Low-threshold detection can be switched off per channel. A per-channel open-load enable is also held here and passed on to the open-load detector.

Software configures one channel per write. The channel select sits at bits 12:11 of the write word. A latched channel stays off until reset or until its own clear strobe is pulsed.

Top module: `ocg_top`

## Requirements
- R1: After reset, every channel is on (`ch_off` = 0), `trip_hi` = 0, `cfg_err` = 0 and `ol_en` is all ones. Every channel uses code 00 with low detection enabled.
- R2: With code 11 (bits 1:0 of the write word), a channel latches off after `lo` has been high for exactly `cyc(CLK_HZ,150)` consecutive clock edges, and not one edge sooner.
- R3: With code 10, a channel latches off after exactly `cyc(CLK_HZ,75000)` consecutive edges of `lo`.
- R4: With code 00, a channel latches off after exactly `cyc(CLK_HZ,155000)` consecutive edges of `lo`. Here `cyc(f,us)` = max(1, f·us/10^6) with integer division.
- R5: Writing the reserved code 01 makes the channel use the code-00 interval, and it sets `cfg_err`. `cfg_err` then stays set until reset.
- R6: If `lo` drops before the interval expires, the count restarts from zero at the next assertion.
- R7: Bit 2 of the write word set to 1 disables low detection for the channel, and `lo` then never turns it off.
- R8: When `hi` has been high for `HI_FILT` consecutive edges, the channel latches off. This happens whatever the code or the low-detection setting. At the same edge `trip_hi` is set for that channel.
- R9: A write (`wr_en` = 1) changes only the channel whose index is in bits 12:11 of `wr_data`.
- R10: Bit 3 of the write word set to 1 drives `ol_en` low for the selected channel, and 0 drives it high.
- R11: A latched channel stays off until reset or a one-cycle pulse on its `clr` bit. After that edge, `ch_off` and `trip_hi` are 0 and both counters restart, even if a flag is still high. The clear wins over a trip in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lo | input | 4 | Per-channel low-threshold comparator flag, synchronous to clk |
| hi | input | 4 | Per-channel high-threshold comparator flag, synchronous to clk |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 16 | Write word: [1:0] code, [2] low-detect disable, [3] open-load disable, [12:11] channel |
| clr | input | 4 | Per-channel fault clear strobe |
| ch_off | output | 4 | Per-channel latched shutdown |
| trip_hi | output | 4 | Per-channel flag: the high-threshold path caused the latch |
| ol_en | output | 4 | Per-channel open-load detection enable |
| cfg_err | output | 1 | Sticky flag: the reserved blanking code was written |

## Verification
A wrong internal counter or limit appears at the ports as a `ch_off` edge one or more cycles away from the exact count. The bench catches this by sampling one edge before the expected trip and again at the trip edge, for each code on parallel channels. A stale or misrouted configuration register appears as the wrong channel tripping, or as a channel tripping at another channel's interval, within one blanking period. A failure to reset the count when `lo` drops, or a clear that does not win, appears within `cyc(CLK_HZ,150)` or `HI_FILT` edges as an early or a missing shutdown.

// File: rtl/ocg_pkg.sv
// Package: shared encodings, widths and cycle conversion for the overcurrent guard.
// Assumes: integer microsecond durations; clock frequency given in Hz.
package ocg_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned SEL_LSB = 11;
    localparam int unsigned SEL_W   = 2;

    typedef enum logic [1:0] {
        BL_LONG  = 2'b00,
        BL_RSV   = 2'b01,
        BL_MID   = 2'b10,
        BL_SHORT = 2'b11
    } blank_code_e;

    typedef struct packed {
        blank_code_e code;
        logic        lo_dis;
        logic        ol_dis;
    } ch_cfg_t;

    localparam longint LONG_US  = 155000;
    localparam longint MID_US   = 75000;
    localparam longint SHORT_US = 150;

    // Converts a duration in microseconds to clock cycles, never below one.
    function automatic longint cyc(longint hz, longint us);
        longint c;
        c = (hz * us) / 64'd1000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/ocg_cfg_regs.sv
// Module: per-channel configuration store and reserved-code detector.
// Does:   decodes one write word, updates only the selected channel, maps the
//         reserved blanking code onto the longest interval and flags it.
// Assumes: wr_en is a single-cycle strobe synchronous to clk.
module ocg_cfg_regs
    import ocg_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [WORD_W-1:0]     wr_data,
    output ch_cfg_t [N_CH-1:0]    cfg,
    output logic                  cfg_err
);

    logic [SEL_W-1:0] sel;
    blank_code_e      wr_code;
    logic             rsv_hit;
    logic             unused_bits;

    // Field extraction from the write word.
    always_comb begin
        sel         = wr_data[SEL_LSB +: SEL_W];
        wr_code     = blank_code_e'(wr_data[1:0]);
        rsv_hit     = wr_en && (wr_code == BL_RSV);
        unused_bits = ^{wr_data[WORD_W-1:SEL_LSB+SEL_W], wr_data[SEL_LSB-1:4]};
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            // Holds this channel's settings; rewritten only when selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg[g] <= '{code: BL_LONG, lo_dis: 1'b0, ol_dis: 1'b0};
                end else if (wr_en && (sel == SEL_W'(g))) begin
                    cfg[g].code   <= (wr_code == BL_RSV) ? BL_LONG : wr_code;
                    cfg[g].lo_dis <= wr_data[2];
                    cfg[g].ol_dis <= wr_data[3];
                end
            end
        end
    endgenerate

    // Sticky record that the reserved code was written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_err <= 1'b0;
        else if (rsv_hit) cfg_err <= 1'b1;
    end

endmodule

// File: rtl/ocg_blank_timer.sv
// Module: low-threshold blanking counter for one channel.
// Does:   counts consecutive cycles of the low flag and raises expire on the
//         edge where the count reaches the interval picked by the code.
// Assumes: lo is already synchronous; the caller latches expire.
module ocg_blank_timer
    import ocg_pkg::*;
#(
    parameter longint CLK_HZ = 125000000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lo,
    input  logic        lo_dis,
    input  blank_code_e code,
    input  logic        clr,
    input  logic        hold,
    output logic        expire
);

    localparam longint LONG_C  = cyc(CLK_HZ, LONG_US);
    localparam longint MID_C   = cyc(CLK_HZ, MID_US);
    localparam longint SHORT_C = cyc(CLK_HZ, SHORT_US);
    localparam int     CW      = $clog2(LONG_C + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          active;

    // Last count value before the interval expires, per code.
    always_comb begin
        unique case (code)
            BL_SHORT: last = CW'(SHORT_C - 1);
            BL_MID:   last = CW'(MID_C - 1);
            default:  last = CW'(LONG_C - 1);
        endcase
        active = lo && !lo_dis && !hold;
        expire = active && (cnt >= last);
    end

    // Consecutive-cycle counter; restarts when the flag drops or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !active || expire) cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ocg_fast_trip.sv
// Module: high-threshold deglitch for one channel.
// Does:   raises trip once hi has been seen on HI_FILT consecutive edges.
// Assumes: HI_FILT clock periods are far below 20 us at the chosen clock.
module ocg_fast_trip #(
    parameter int unsigned HI_FILT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi,
    input  logic clr,
    output logic trip
);

    localparam int HW = $clog2(HI_FILT + 1);

    logic [HW-1:0] cnt;

    // Trip decision from the current count and flag.
    always_comb trip = hi && (cnt >= HW'(HI_FILT - 1));

    // Saturating run-length counter of the high flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !hi) cnt <= '0;
        else if (!trip)           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ocg_top.sv
// Module: overcurrent blanking and latch-off timer for N_CH channels.
// Does:   combines the per-channel blanking timer and fast trip into a latched
//         shutdown, and exposes the open-load enable and config error.
// Assumes: comparator flags are synchronous to clk; clear has priority.
module ocg_top
    import ocg_pkg::*;
#(
    parameter int unsigned N_CH    = 4,
    parameter longint      CLK_HZ  = 125000000,
    parameter int unsigned HI_FILT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   lo,
    input  logic [N_CH-1:0]   hi,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [N_CH-1:0]   clr,
    output logic [N_CH-1:0]   ch_off,
    output logic [N_CH-1:0]   trip_hi,
    output logic [N_CH-1:0]   ol_en,
    output logic              cfg_err
);

    ch_cfg_t [N_CH-1:0] cfg;

    ocg_cfg_regs #(.N_CH(N_CH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .cfg_err (cfg_err)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            logic lo_exp;
            logic hi_trip;

            ocg_blank_timer #(.CLK_HZ(CLK_HZ)) u_blank (
                .clk    (clk),
                .rst_n  (rst_n),
                .lo     (lo[g]),
                .lo_dis (cfg[g].lo_dis),
                .code   (cfg[g].code),
                .clr    (clr[g]),
                .hold   (ch_off[g]),
                .expire (lo_exp)
            );

            ocg_fast_trip #(.HI_FILT(HI_FILT)) u_fast (
                .clk   (clk),
                .rst_n (rst_n),
                .hi    (hi[g]),
                .clr   (clr[g]),
                .trip  (hi_trip)
            );

            // Shutdown latch: set by either path, cleared by strobe or reset.
            always_ff @(posedge clk) begin
                if (!rst_n || clr[g]) begin
                    ch_off[g]  <= 1'b0;
                    trip_hi[g] <= 1'b0;
                end else begin
                    if (lo_exp || hi_trip) ch_off[g]  <= 1'b1;
                    if (hi_trip)           trip_hi[g] <= 1'b1;
                end
            end

            // Open-load enable follows the stored disable bit.
            always_comb ol_en[g] = !cfg[g].ol_dis;
        end
    endgenerate

endmodule

// File: rtl/ocg_chk.sv
// Module: assertion checker bound to ocg_top.
// Does:   checks latch holding, trip causes, clear priority and sticky flags.
module ocg_chk
    import ocg_pkg::*;
#(
    parameter int unsigned N_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_CH-1:0]   lo,
    input logic [N_CH-1:0]   hi,
    input logic              wr_en,
    input logic [WORD_W-1:0] wr_data,
    input logic [N_CH-1:0]   clr,
    input logic [N_CH-1:0]   ch_off,
    input logic [N_CH-1:0]   trip_hi,
    input logic [N_CH-1:0]   ol_en,
    input logic              cfg_err
);

    // R5: the error flag never drops without reset.
    assert_cfg_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R10: open-load enables change only on a write.
    assert_ol_en_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ol_en));

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            // R11: a latched channel stays off until its clear.
            assert_latch_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_off[g] && !clr[g]) |=> ch_off[g]);

            // R11: clear always wins at the following edge.
            assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
                clr[g] |=> (!ch_off[g] && !trip_hi[g]));

            // R8: a high-path trip needs the high flag present.
            assert_hi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(trip_hi[g]) |-> $past(hi[g]));

            // R7: a shutdown needs one of the comparator flags present.
            assert_off_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ch_off[g]) |-> $past(lo[g] || hi[g]));
        end
    endgenerate

endmodule

bind ocg_top ocg_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/sim_ocg_top.sv
module sim_ocg_top;
    import ocg_pkg::*;

    localparam longint CLK_HZ  = 100000;
    localparam int     HF      = 2;
    localparam int     T_LONG  = int'(cyc(CLK_HZ, 155000));
    localparam int     T_MID   = int'(cyc(CLK_HZ, 75000));
    localparam int     T_SHORT = int'(cyc(CLK_HZ, 150));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  lo = '0, hi = '0, clr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  ch_off, trip_hi, ol_en;
    logic        cfg_err;
    int          n_chk = 0, n_bad = 0;
    int          el;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ocg_top #(.N_CH(4), .CLK_HZ(CLK_HZ), .HI_FILT(HF)) u0 (
        .clk(clk), .rst_n(rst_n), .lo(lo), .hi(hi), .wr_en(wr_en),
        .wr_data(wr_data), .clr(clr), .ch_off(ch_off), .trip_hi(trip_hi),
        .ol_en(ol_en), .cfg_err(cfg_err));

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int ch, logic [1:0] code, logic lod, logic old);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = '0;
        wr_data[12:11] = 2'(ch);
        wr_data[3] = old; wr_data[2] = lod; wr_data[1:0] = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        el += n;
    endtask

    task automatic clear_all;
        @(negedge clk); clr = 4'hF; lo = '0; hi = '0;
        @(negedge clk); clr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ch_off", {4'h0, ch_off}, 8'h00);
        chk("R1 trip_hi", {4'h0, trip_hi}, 8'h00);
        chk("R1 ol_en", {4'h0, ol_en}, 8'h0F);
        chk("R1 cfg_err", {7'h0, cfg_err}, 8'h00);

        // R9 R10: only channel 2 loses its open-load enable
        wr(2, 2'b11, 1'b0, 1'b1);
        chk("R10 ol_en ch2", {4'h0, ol_en}, 8'h0B);
        wr(2, 2'b11, 1'b0, 1'b0);
        chk("R10 ol_en restored", {4'h0, ol_en}, 8'h0F);

        // parallel sweep: ch0 default long, ch1 mid, ch2 short, ch3 disabled
        wr(1, 2'b10, 1'b0, 1'b0);
        wr(3, 2'b00, 1'b1, 1'b0);
        chk("R9 ol_en untouched", {4'h0, ol_en}, 8'h0F);
        lo = 4'hF; el = 0;
        step(T_SHORT - 1);
        chk("R2 short early", {4'h0, ch_off}, 8'h00);
        step(1);
        chk("R2 short trip", {4'h0, ch_off}, 8'h04);
        step(T_MID - 1 - el);
        chk("R3 mid early", {4'h0, ch_off}, 8'h04);
        step(1);
        chk("R3 mid trip R9", {4'h0, ch_off}, 8'h06);
        step(T_LONG - 1 - el);
        chk("R4 long early", {4'h0, ch_off}, 8'h06);
        step(1);
        chk("R4 long trip", {4'h0, ch_off}, 8'h07);
        step(200);
        chk("R7 disabled ignores lo", {4'h0, ch_off}, 8'h07);
        chk("R8 no hi cause", {4'h0, trip_hi}, 8'h00);
        chk("R11 latch holds", {4'h0, ch_off}, 8'h07);
        clear_all;
        chk("R11 cleared", {4'h0, ch_off}, 8'h00);

        // R6: interrupted low excursion restarts the count (ch2 short)
        lo[2] = 1'b1; el = 0;
        step(T_SHORT - 1);
        lo[2] = 1'b0;
        step(1);
        lo[2] = 1'b1; el = 0;
        step(T_SHORT - 1);
        chk("R6 restart early", {4'h0, ch_off}, 8'h00);
        step(1);
        chk("R6 restart trip", {4'h0, ch_off}, 8'h04);
        clear_all;

        // R8: high path ignores lo disable and long code
        hi[3] = 1'b1; el = 0;
        step(HF - 1);
        chk("R8 hi early", {4'h0, ch_off}, 8'h00);
        step(1);
        chk("R8 hi trip", {4'h0, ch_off}, 8'h08);
        chk("R8 trip_hi", {4'h0, trip_hi}, 8'h08);
        // R11: clear while hi persists; count restarts
        @(negedge clk); clr[3] = 1'b1;
        @(negedge clk); clr[3] = 1'b0;
        chk("R11 clear wins", {4'h0, ch_off}, 8'h00);
        chk("R11 trip_hi cleared", {4'h0, trip_hi}, 8'h00);
        step(HF - 1);
        chk("R11 restart early", {4'h0, ch_off}, 8'h00);
        step(1);
        chk("R11 restart trip", {4'h0, ch_off}, 8'h08);
        clear_all;

        // R5: reserved code acts as long and sets sticky error
        wr(1, 2'b01, 1'b0, 1'b0);
        chk("R5 cfg_err set", {7'h0, cfg_err}, 8'h01);
        lo[1] = 1'b1; el = 0;
        step(T_MID);
        chk("R5 not mid", {4'h0, ch_off}, 8'h00);
        step(T_LONG - 1 - el);
        chk("R5 long early", {4'h0, ch_off}, 8'h00);
        step(1);
        chk("R5 long trip", {4'h0, ch_off}, 8'h02);
        wr(1, 2'b11, 1'b0, 1'b0);
        chk("R5 cfg_err sticky", {7'h0, cfg_err}, 8'h01);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule